// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block holds two independent 32-bit timers that count down. Software programs them through a small register window on a simple 32-bit read/write bus. Each timer has its own enable, its own choice of one-shot or periodic operation, and its own tick source. The tick source is either an external reference tick enable, or the main clock slowed by a power-of-two prescaler. When a timer expires it latches a flag in a shared status register. Each flag drives one interrupt line as a level until software clears it.

A timer that is loaded with all ones and reloads from all ones acts as a free-running counter that can be read at any time. A timer with reload disabled delivers a single event after its programmed count and then stops itself. With reload enabled it gives a steady stream of events whose period is the reload value plus one.

Register accesses take one cycle. A write lands on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the current register state while `bus_en` is high and `bus_we` is low. No stream traffic passes through the block, so it has no valid/ready pair and never applies back-pressure.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, every register reads as zero and both interrupt lines are low.
- R2: Byte offsets are 0x00 control, 0x04 status, 0x10 and 0x14 for timer 0 reload and count, 0x18 and 0x1C for timer 1 reload and count. Any other offset reads zero and ignores writes. Control bits outside the implemented set (0-3, 11, 12, 19-24) read zero, so writing all ones to control reads back 0x01F8180F.
- R3: Writing a count register loads that value on the same edge. This load overrides any tick and suppresses an expiry in that cycle.
- R4: An enabled timer decrements by one on each of its ticks. A disabled timer, or a cycle without a tick, leaves the count unchanged.
- R5: Control bit 11 (timer 0) or bit 12 (timer 1) selects the external reference tick. When the bit is clear, the timer ticks on the main clock divided by 2^k. Here k is control bits 21:19 for timer 0 and bits 24:22 for timer 1. Such a tick falls on the cycles where the cycle count since reset, modulo 2^k, equals 2^k-1, so k=0 ticks every cycle.
- R6: A tick taken while an enabled count is zero sets that timer's flag: status bit 0 for timer 0, status bit 8 for timer 1. `irq[i]` equals that flag.
- R7: With reload enable set (control bit 1 for timer 0, bit 3 for timer 1), expiry loads the reload value, so a reload value of N gives one event every N+1 ticks.
- R8: With reload enable clear, expiry clears that timer's enable bit in control and the count stays at zero, so exactly one event is produced.
- R9: Writing status clears each flag whose bit is written as zero and leaves unchanged each flag whose bit is written as one. When a clear and an expiry coincide, the flag ends up set.
- R10: The two timers share no state other than the control and status words. Activity on one never changes the count, flag or enable of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | External reference tick enable, one cycle per tick |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq | output | 2 | Level interrupt per timer, equal to its status flag |

## Verification
The hardest case to reach from the ports is a status clear that falls on the very edge where a timer expires, because that edge depends on the prescaler phase and the reload value. The stimulus runs a timer periodically at divide-by-one with a short reload and holds a status-clearing write for many consecutive cycles, so some of those writes are certain to land on an expiry. A second narrow case is a count write on the exact edge where an enabled timer sits at zero. The stimulus reaches it with back-to-back writes (zero count, enable, new count) on three consecutive edges.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_STAT   = 'h04;
  localparam int OFF_RLD0   = 'h10;
  localparam int OFF_STRIDE = 8;
  localparam int OFF_VAL_GAP = 4;
  localparam int SRC_BASE   = 11;
  localparam int DIV_BASE   = 19;
  localparam int FLAG_STEP  = 8;

  function automatic logic [31:0] ctrl_mask(input int div_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      m[2*i]          = 1'b1;
      m[2*i+1]        = 1'b1;
      m[SRC_BASE + i] = 1'b1;
      for (int b = 0; b < div_w; b++) m[DIV_BASE + div_w*i + b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] flag_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_TIMERS; i++) m[FLAG_STEP*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int NT    = 2,
  parameter int DIV_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_tick,
  input  logic [NT-1:0]             ref_sel,
  input  logic [NT-1:0][DIV_W-1:0]  div_sel,
  output logic [NT-1:0]             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NT; i++) begin : g_src
    logic fab;
    // low div_sel bits all ones marks the last cycle of each 2^k window
    assign fab     = &(pre_q | ({PRE_W{1'b1}} << div_sel[i]));
    assign tick[i] = ref_sel[i] ? ref_tick : fab;

    AST_FABRIC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (fab && div_sel[i] != '0) |=> (!fab || div_sel[i] != $past(div_sel[i]))); // R5
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             reload_en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;
  logic             at_zero;
  logic             step;

  assign at_zero = (count_q == '0);
  assign step    = enable & tick;
  assign expire  = step & at_zero & ~load_wr;
  assign count   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_wr) begin
      count_q <= load_val;
    end else if (step) begin
      if (at_zero) count_q <= reload_en ? reload_val : '0;
      else         count_q <= count_q - 1'b1;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_q == $past(load_val)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && count_q != '0 && !load_wr) |=> count_q == $past(count_q) - CNT_W'(1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(enable && tick) && !load_wr) |=> $stable(count_q)); // R4
  AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_en) |=> count_q == $past(reload_val)); // R7
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_en) |=> count_q == '0); // R8
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        irq
);
  import dct_pkg::*;

  localparam int NT = NUM_TIMERS;
  localparam logic [31:0] CMASK = ctrl_mask(DIV_W);
  localparam logic [31:0] FMASK = flag_mask();

  logic [31:0] ctrl_q, ctrl_d;
  logic [31:0] stat_q, stat_d;
  logic [NT-1:0][CNT_W-1:0] rld_q;
  logic [NT-1:0][CNT_W-1:0] cnt;
  logic [NT-1:0] exp_w, tick_w, val_wr, rld_wr, ref_sel;
  logic [NT-1:0][DIV_W-1:0] div_sel;
  logic wr, rd, ctrl_wr, stat_wr;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign ctrl_wr = wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign stat_wr = wr && (bus_addr == ADDR_W'(OFF_STAT));

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam int EN_B = 2*i;
    localparam int RL_B = 2*i + 1;
    localparam int FL_B = FLAG_STEP*i;
    localparam int RLD_OFF = OFF_RLD0 + OFF_STRIDE*i;

    assign rld_wr[i]  = wr && (bus_addr == ADDR_W'(RLD_OFF));
    assign val_wr[i]  = wr && (bus_addr == ADDR_W'(RLD_OFF + OFF_VAL_GAP));
    assign ref_sel[i] = ctrl_q[SRC_BASE + i];
    assign div_sel[i] = ctrl_q[DIV_BASE + DIV_W*i +: DIV_W];
    assign irq[i]     = stat_q[FL_B];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rld_q[i] <= '0;
      else if (rld_wr[i]) rld_q[i] <= bus_wdata[CNT_W-1:0];
    end

    dct_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_w[i]),
      .enable     (ctrl_q[EN_B]),
      .reload_en  (ctrl_q[RL_B]),
      .load_wr    (val_wr[i]),
      .load_val   (bus_wdata[CNT_W-1:0]),
      .reload_val (rld_q[i]),
      .count      (cnt[i]),
      .expire     (exp_w[i])
    );

    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      exp_w[i] |=> stat_q[FL_B]); // R6
    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_w[i] && !ctrl_q[RL_B]) |=> !ctrl_q[EN_B]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[FL_B] && !stat_wr) |=> stat_q[FL_B]); // R9
  end

  dct_prescaler #(.NT(NT), .DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .ref_sel  (ref_sel),
    .div_sel  (div_sel),
    .tick     (tick_w)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata & CMASK;
    for (int i = 0; i < NT; i++) begin
      if (exp_w[i] && !ctrl_q[2*i+1]) ctrl_d[2*i] = 1'b0;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_q & (bus_wdata | ~FMASK);
    for (int i = 0; i < NT; i++) begin
      if (exp_w[i]) stat_d[FLAG_STEP*i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = stat_q;
      for (int i = 0; i < NT; i++) begin
        if (bus_addr == ADDR_W'(OFF_RLD0 + OFF_STRIDE*i))
          bus_rdata = 32'(rld_q[i]);
        if (bus_addr == ADDR_W'(OFF_RLD0 + OFF_STRIDE*i + OFF_VAL_GAP))
          bus_rdata = 32'(cnt[i]);
      end
    end
  end

  AST_STATUS_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~FMASK) == '0); // R2
  AST_CTRL_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q & ~CMASK) == '0); // R2
endmodule

// File: tb/dual_countdown_timer_bench.sv
module dual_countdown_timer_bench;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_tick;
  logic bus_en, bus_we;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  bit ref_on = 0;
  bit finished = 0;
  int ref_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_countdown_timer u_dual_countdown_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference tick: one pulse every third cycle while enabled
  always @(negedge clk) begin
    ref_cnt <= ref_cnt + 1;
    ref_tick <= ref_on && (ref_cnt % 3 == 0);
  end

  // behavioural reference model
  logic [31:0] m_ctrl, m_stat;
  logic [31:0] m_cnt [2];
  logic [31:0] m_rld [2];
  int m_cyc;

  always @(posedge clk) begin
    logic [31:0] nctrl, nstat;
    logic [31:0] ncnt [2];
    bit w;
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; m_cyc = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_rld[i] = 0; end
    end else begin
      w = bus_en && bus_we;
      nctrl = (w && bus_addr == 6'h00) ? (bus_wdata & 32'h01F8180F) : m_ctrl;
      nstat = m_stat;
      if (w && bus_addr == 6'h04) begin
        if (!bus_wdata[0]) nstat[0] = 1'b0;
        if (!bus_wdata[8]) nstat[8] = 1'b0;
      end
      for (int i = 0; i < 2; i++) begin
        bit en, rl, tk, vw, ex;
        int k;
        en = m_ctrl[2*i];
        rl = m_ctrl[2*i+1];
        k  = int'((m_ctrl >> (19 + 3*i)) & 32'h7);
        tk = m_ctrl[11+i] ? ref_tick : ((m_cyc % (1 << k)) == (1 << k) - 1);
        vw = w && bus_addr == 6'(20 + 8*i);
        ex = en && tk && m_cnt[i] == 0 && !vw;
        if (vw)             ncnt[i] = bus_wdata;
        else if (en && tk)  ncnt[i] = (m_cnt[i] == 0) ? (rl ? m_rld[i] : 0) : m_cnt[i] - 1;
        else                ncnt[i] = m_cnt[i];
        if (ex) begin
          nstat[8*i] = 1'b1;
          if (!rl) nctrl[2*i] = 1'b0;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (w && bus_addr == 6'(16 + 8*i)) m_rld[i] = bus_wdata;
        m_cnt[i] = ncnt[i];
      end
      m_ctrl = nctrl; m_stat = nstat; m_cyc++;
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return m_ctrl;
      6'h04: return m_stat;
      6'h10: return m_rld[0];
      6'h14: return m_cnt[0];
      6'h18: return m_rld[1];
      6'h1C: return m_cnt[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: interrupt lines against the model flags (R6, R9, R10)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished)
      chk("R6 irq level vs model", {30'h0, irq}, {30'h0, m_stat[8], m_stat[0]});
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(string tag, logic [5:0] a);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_lit(string tag, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd_lit("R1 ctrl", 6'h00, 0);
    rd_lit("R1 status", 6'h04, 0);
    rd_lit("R1 t0 reload", 6'h10, 0);
    rd_lit("R1 t0 count", 6'h14, 0);
    rd_lit("R1 t1 reload", 6'h18, 0);
    rd_lit("R1 t1 count", 6'h1C, 0);
    chk("R1 irq", {30'h0, irq}, 0);

    // R2 unmapped offsets and control masking
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd_lit("R2 unmapped 0x08", 6'h08, 0);
    rd_lit("R2 unmapped 0x3C", 6'h3C, 0);
    rd_lit("R2 ctrl untouched", 6'h00, 0);
    wr(6'h00, 32'hFFFF_FFFF);
    rd_lit("R2 ctrl mask", 6'h00, 32'h01F8180F);
    wr(6'h00, 0);
    wr(6'h14, 0); wr(6'h1C, 0); wr(6'h04, 0);
    idle(2);

    // R4 free-running and hold
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h00, 32'h1);
    idle(10);
    rd("R4 free-running count", 6'h14);
    wr(6'h00, 0);
    idle(1);
    rd("R4 held count a", 6'h14);
    idle(5);
    rd_lit("R4 held count b", 6'h14, m_cnt[0]);

    // R8 one-shot
    wr(6'h14, 5);
    wr(6'h00, 32'h1);
    idle(10);
    rd_lit("R8 enable self-cleared", 6'h00, 0);
    rd_lit("R8 count parked", 6'h14, 0);
    rd_lit("R6 t0 flag", 6'h04, 32'h1);
    chk("R6 irq0 high", {30'h0, irq}, 2'b01);

    // R9 write-one keeps, write-zero clears
    wr(6'h04, 32'hFFFF_FFFF);
    rd_lit("R9 write-one keeps", 6'h04, 32'h1);
    wr(6'h04, 32'hFFFF_FFFE);
    rd_lit("R9 write-zero clears", 6'h04, 0);
    idle(10);
    rd_lit("R8 single event", 6'h04, 0);

    // R7 periodic on reference tick (timer 1), R10 timer 0 untouched
    ref_on = 1;
    wr(6'h18, 3);
    wr(6'h1C, 3);
    wr(6'h00, 32'h0000_100C);
    idle(40);
    rd("R7 t1 count", 6'h1C);
    rd("R7 t1 flag", 6'h04);
    rd_lit("R10 t0 count still parked", 6'h14, 0);

    // R5 prescaled fabric tick, divide by 32 (timer 0), timer 1 keeps running
    wr(6'h04, 0);
    wr(6'h10, 2);
    wr(6'h14, 2);
    wr(6'h00, 32'h0000_100C | 32'h3 | (32'd5 << 19));
    for (int c = 0; c < 6; c++) begin
      idle(50);
      rd("R5 t0 prescaled count", 6'h14);
      rd("R5 status", 6'h04);
    end
    rd("R10 t1 count", 6'h1C);

    // R9 clear coinciding with expiry: held clear writes, divide by one
    wr(6'h00, 32'h3);
    wr(6'h10, 3);
    wr(6'h14, 3);
    for (int c = 0; c < 12; c++) wr(6'h04, 0);
    rd("R9 set wins over clear", 6'h04);
    idle(3);

    // R3 count write on the zero-expiry edge
    wr(6'h00, 0);
    wr(6'h04, 0);
    wr(6'h14, 0);
    wr(6'h00, 32'h1);
    wr(6'h14, 7);
    idle(1);
    rd_lit("R3 expiry suppressed by load", 6'h04, 0);
    rd("R3 loaded count", 6'h14);
    idle(20);
    rd("R3 later expiry", 6'h04);
    rd("R3 ctrl after", 6'h00);

    idle(2);
    finish_run();
  end
endmodule